// File: doc/BRIEF.md
# Reconfigurable Lane Serializer / Deserializer

This block is a 40-bit shift register. It works either as a parallel-to-serial multiplexer or as a serial-to-parallel demultiplexer, and everything runs on a single fast clock. A 3-bit ratio code chooses one of eight ratios, from 4 up to 40. Each ratio divides the 40 storage bits into a fixed number of independent lanes, and each lane is N bits wide, where N is the ratio. In the serializer direction, a 40-bit parallel word is taken in on a word-strobe cycle. Every active lane then sends its slice MSB first, one bit per cycle on its own serial output. In the deserializer direction, each active lane shifts in one bit per cycle. On every strobe cycle the assembled lane slices are written to the parallel output.

The word strobe comes from one of two sources. The internal source is a counter that fires once every N cycles. The external source is an input pin. The direction, the ratio code and the strobe source are all captured during synchronous reset. A change to them only matters after the next reset.

The controller is a four-state machine. The serializer direction uses MUX_PRIME (no word loaded yet) and MUX_STREAM (words flowing). The deserializer direction uses DMX_FILL (no word presented yet) and DMX_STREAM. Reset enters MUX_PRIME when dir_i is 0 and DMX_FILL when dir_i is 1. On the first strobe, MUX_PRIME moves to MUX_STREAM and DMX_FILL moves to DMX_STREAM. Both stream states hold until reset.

Top module: `ser_shift_top`

## Requirements
- R1: While rst is high, dir_i (0 = serializer, 1 = deserializer), ratio_sel_i and tsrc_ext_i are captured. Changes to these inputs while rst is low have no effect on any output.
- R2: ratio_sel_i codes 0..7 give ratios N = 4, 5, 8, 10, 16, 20, 32, 40. Lane k uses parallel bits [k*N+N-1 : k*N] and serial pin k.
- R3: With tsrc_ext_i captured as 0, stb_o is high in the first cycle after reset release and then every N cycles after that. It is low in all other cycles.
- R4: With tsrc_ext_i captured as 1, stb_o equals ext_stb_i in every cycle after reset release.
- R5: In the serializer direction, par_i is captured in a cycle where stb_o is high. In the j-th following cycle (j = 1..N), ser_o[k] equals captured bit k*N+N-j. A strobe in the N-th following cycle continues the stream with no gap.
- R6: Serializer active lanes for codes 0..7 are 8, 8, 5, 4, 2, 2, 1, 1. ser_o is 0 on inactive lanes, before the first strobe, once a word is exhausted without a new strobe, and at all times in the deserializer direction.
- R7: Deserializer active lanes for codes 0..7 are 10, 8, 5, 4, 2, 2, 1, 1. After a strobe cycle, par_o bit k*N+i equals ser_i[k] as sampled i cycles before that strobe cycle (i = 0 is the strobe cycle). Samples from before reset release count as 0.
- R8: par_o changes only in the cycle after a strobe. Bits outside the active lanes read 0, and par_o is 0 in the serializer direction.
- R9: In the first cycle after reset release, par_o and ser_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for all state |
| rst | input | 1 | Synchronous active-high reset, also captures the configuration |
| dir_i | input | 1 | Direction: 0 serializer, 1 deserializer |
| ratio_sel_i | input | 3 | Ratio code |
| tsrc_ext_i | input | 1 | Strobe source: 1 external pin, 0 internal counter |
| ext_stb_i | input | 1 | External word strobe |
| par_i | input | 40 | Parallel word to serialize |
| ser_i | input | 10 | One serial input bit per lane |
| ser_o | output | 10 | One serial output bit per lane |
| par_o | output | 40 | Assembled parallel word |
| stb_o | output | 1 | Word strobe in use |

## Verification
The bench runs both directions over all eight ratio codes with both strobe sources. It goes after the following corner cases and the failure each one would expose:

- **Ratio code 0.** The two directions disagree on the lane count here. A design that shared one table would drive lanes 8 and 9 when serializing, or drop the top 8 bits when deserializing.
- **External strobes.** These come back to back or with gaps. They expose a design that leaves a bubble between words, or fails to zero-fill once a word is exhausted.
- **Configuration changes mid-run.** The bench changes the direction and ratio inputs while the block is running. A design that reads them outside reset would change its lane layout.
- **Long strobe-free stretches.** These catch a deserializer output that drifts between strobes.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int WORD_W   = 40;
    localparam int LANE_MAX = 10;
    localparam int SEL_W    = 3;
    localparam int RATIO_W  = $clog2(WORD_W + 1);
    localparam int LANE_W   = $clog2(LANE_MAX + 1);
    localparam int IDX_W    = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_MUX_PRIME  = 2'd0,
        ST_MUX_STREAM = 2'd1,
        ST_DMX_FILL   = 2'd2,
        ST_DMX_STREAM = 2'd3
    } ser_state_e;

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'd0:    r = RATIO_W'(4);
            3'd1:    r = RATIO_W'(5);
            3'd2:    r = RATIO_W'(8);
            3'd3:    r = RATIO_W'(10);
            3'd4:    r = RATIO_W'(16);
            3'd5:    r = RATIO_W'(20);
            3'd6:    r = RATIO_W'(32);
            default: r = RATIO_W'(40);
        endcase
        return r;
    endfunction

    function automatic logic [LANE_W-1:0] lanes_of(input logic dmx, input logic [SEL_W-1:0] code);
        logic [LANE_W-1:0] l;
        case (code)
            3'd0:    l = dmx ? LANE_W'(10) : LANE_W'(8);
            3'd1:    l = LANE_W'(8);
            3'd2:    l = LANE_W'(5);
            3'd3:    l = LANE_W'(4);
            3'd4:    l = LANE_W'(2);
            3'd5:    l = LANE_W'(2);
            default: l = LANE_W'(1);
        endcase
        return l;
    endfunction

    // one bit set at the lowest position of every active lane
    function automatic logic [WORD_W-1:0] lane_base_mask(input logic [RATIO_W-1:0] ratio,
                                                         input logic [LANE_W-1:0] lanes);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < LANE_MAX; k++) begin
            if (k < int'(lanes)) m[IDX_W'(k * int'(ratio))] = 1'b1;
        end
        return m;
    endfunction

    // bits covered by active lanes
    function automatic logic [WORD_W-1:0] used_mask(input logic [RATIO_W-1:0] ratio,
                                                    input logic [LANE_W-1:0] lanes);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i < int'(ratio) * int'(lanes));
        end
        return m;
    endfunction
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
    import ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               dir_i,
    input  logic [SEL_W-1:0]   ratio_sel_i,
    input  logic               tsrc_ext_i,
    input  logic               stb_i,
    output ser_state_e         state_o,
    output logic               ext_o,
    output logic               dmx_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [LANE_W-1:0]  lanes_o
);
    ser_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             ext_q;

    // state register; configuration captured only in reset
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= dir_i ? ST_DMX_FILL : ST_MUX_PRIME;
            sel_q   <= ratio_sel_i;
            ext_q   <= tsrc_ext_i;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MUX_PRIME:  if (stb_i) state_d = ST_MUX_STREAM;
            ST_MUX_STREAM: state_d = ST_MUX_STREAM;
            ST_DMX_FILL:   if (stb_i) state_d = ST_DMX_STREAM;
            ST_DMX_STREAM: state_d = ST_DMX_STREAM;
        endcase
    end

    // outputs
    always_comb begin
        state_o = state_q;
        ext_o   = ext_q;
        dmx_o   = (state_q == ST_DMX_FILL) || (state_q == ST_DMX_STREAM);
        ratio_o = ratio_of(sel_q);
        lanes_o = lanes_of(dmx_o, sel_q);
    end

    p_dir_locked_r1: assert property (@(posedge clk) disable iff (rst)
        dmx_o |=> dmx_o);
    p_dir_locked_mux_r1: assert property (@(posedge clk) disable iff (rst)
        !dmx_o |=> !dmx_o);
    p_cfg_locked_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(ratio_o) && $stable(ext_o) && $stable(lanes_o)));
    p_stream_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MUX_STREAM) |=> (state_q == ST_MUX_STREAM));
endmodule

// File: rtl/ser_timing.sv
module ser_timing
    import ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_sel_i,
    input  logic               ext_stb_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               stb_o
);
    logic [RATIO_W-1:0] cnt_q;
    logic               int_stb;

    always_ff @(posedge clk) begin
        if (rst)                              cnt_q <= '0;
        else if (cnt_q == ratio_i - RATIO_W'(1)) cnt_q <= '0;
        else                                  cnt_q <= cnt_q + RATIO_W'(1);
    end

    always_comb begin
        int_stb = (cnt_q == '0);
        stb_o   = !rst && (ext_sel_i ? ext_stb_i : int_stb);
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio_i);
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == ratio_i - RATIO_W'(1)) |=> (cnt_q == '0));
    p_int_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (!ext_sel_i && stb_o) |=> !stb_o);
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
    import ser_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  ser_state_e          state_i,
    input  logic [RATIO_W-1:0]  ratio_i,
    input  logic [LANE_W-1:0]   lanes_i,
    input  logic                stb_i,
    input  logic [WORD_W-1:0]   par_i,
    input  logic [LANE_MAX-1:0] ser_i,
    output logic [LANE_MAX-1:0] ser_o,
    output logic [WORD_W-1:0]   par_o
);
    logic [WORD_W-1:0]   sh_q, par_q, sh_nxt, base_m, used_m, fill;
    logic [LANE_MAX-1:0] lane_en;
    logic                dmx, streaming;
    logic                par_msb0;

    always_comb begin
        dmx       = (state_i == ST_DMX_FILL) || (state_i == ST_DMX_STREAM);
        streaming = (state_i == ST_MUX_STREAM);
        base_m    = lane_base_mask(ratio_i, lanes_i);
        used_m    = used_mask(ratio_i, lanes_i);
        fill      = '0;
        for (int k = 0; k < LANE_MAX; k++) begin
            lane_en[k] = (k < int'(lanes_i));
            if (lane_en[k] && dmx) fill[IDX_W'(k * int'(ratio_i))] = ser_i[k];
        end
        // left shift within each lane; lowest lane bit takes the fill bit
        sh_nxt   = ({sh_q[WORD_W-2:0], 1'b0} & ~base_m) | fill;
        par_msb0 = par_i[IDX_W'(int'(ratio_i) - 1)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            par_q <= '0;
        end else if (dmx) begin
            sh_q <= sh_nxt;
            if (stb_i) par_q <= sh_nxt & used_m;
        end else begin
            sh_q <= stb_i ? (par_i & used_m) : sh_nxt;
        end
    end

    always_comb begin
        par_o = par_q;
        for (int k = 0; k < LANE_MAX; k++) begin
            ser_o[k] = streaming && lane_en[k] &&
                       sh_q[IDX_W'(k * int'(ratio_i) + int'(ratio_i) - 1)];
        end
    end

    p_par_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (dmx && !stb_i) |=> $stable(par_o));
    p_par_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (par_o & ~used_m) == '0);
    p_mux_par_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !dmx |-> (par_o == '0));
    p_idle_lane_r6: assert property (@(posedge clk) disable iff (rst)
        (ser_o & ~lane_en) == '0);
    p_dmx_ser_zero_r6: assert property (@(posedge clk) disable iff (rst)
        dmx |-> (ser_o == '0));
    p_load_msb_r5: assert property (@(posedge clk) disable iff (rst)
        (!dmx && stb_i) |=> (ser_o[0] == $past(par_msb0)));
endmodule

// File: rtl/ser_shift_top.sv
module ser_shift_top
    import ser_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                dir_i,
    input  logic [SEL_W-1:0]    ratio_sel_i,
    input  logic                tsrc_ext_i,
    input  logic                ext_stb_i,
    input  logic [WORD_W-1:0]   par_i,
    input  logic [LANE_MAX-1:0] ser_i,
    output logic [LANE_MAX-1:0] ser_o,
    output logic [WORD_W-1:0]   par_o,
    output logic                stb_o
);
    ser_state_e         state;
    logic               ext_sel, dmx, stb;
    logic [RATIO_W-1:0] ratio;
    logic [LANE_W-1:0]  lanes;

    ser_ctrl u_ctrl (
        .clk(clk), .rst(rst), .dir_i(dir_i), .ratio_sel_i(ratio_sel_i),
        .tsrc_ext_i(tsrc_ext_i), .stb_i(stb), .state_o(state), .ext_o(ext_sel),
        .dmx_o(dmx), .ratio_o(ratio), .lanes_o(lanes)
    );

    ser_timing u_timing (
        .clk(clk), .rst(rst), .ext_sel_i(ext_sel), .ext_stb_i(ext_stb_i),
        .ratio_i(ratio), .stb_o(stb)
    );

    ser_datapath u_dp (
        .clk(clk), .rst(rst), .state_i(state), .ratio_i(ratio), .lanes_i(lanes),
        .stb_i(stb), .par_i(par_i), .ser_i(ser_i), .ser_o(ser_o), .par_o(par_o)
    );

    assign stb_o = stb;

    p_first_strobe_r3: assert property (@(posedge clk)
        (rst && !tsrc_ext_i) |=> (rst || stb_o));
    p_dir_state_r1: assert property (@(posedge clk) disable iff (rst)
        dmx |-> ((state == ST_DMX_FILL) || (state == ST_DMX_STREAM)));
endmodule

// File: tb/tb_ser_shift_top.sv
`timescale 1ns/1ps
module tb_ser_shift_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_i = 1'b0;
    logic [2:0]  ratio_sel_i = '0;
    logic        tsrc_ext_i = 1'b0;
    logic        ext_stb_i = 1'b0;
    logic [39:0] par_i = '0;
    logic [9:0]  ser_i = '0;
    logic [9:0]  ser_o;
    logic [39:0] par_o;
    logic        stb_o;

    always #2.5 clk = ~clk;

    ser_shift_top dut (
        .clk(clk), .rst(rst), .dir_i(dir_i), .ratio_sel_i(ratio_sel_i),
        .tsrc_ext_i(tsrc_ext_i), .ext_stb_i(ext_stb_i), .par_i(par_i),
        .ser_i(ser_i), .ser_o(ser_o), .par_o(par_o), .stb_o(stb_o)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    int          m_dmx, m_ext, m_n, m_l, m_pos, m_cyc;
    logic [39:0] m_word, m_par;
    logic [39:0] m_hist [10];
    bit          first_cyc;

    function automatic int b_ratio(int code);
        int t [8] = '{4, 5, 8, 10, 16, 20, 32, 40};
        return t[code];
    endfunction

    function automatic int b_lanes(int dmx, int code);
        if (!dmx && code == 0) return 8;
        return 40 / b_ratio(code);
    endfunction

    task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(int dmx, int code, int ext);
        @(negedge clk);
        rst = 1'b1; dir_i = dmx[0]; ratio_sel_i = code[2:0]; tsrc_ext_i = ext[0];
        ext_stb_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_dmx = dmx; m_ext = ext; m_n = b_ratio(code); m_l = b_lanes(dmx, code);
        m_pos = 0; m_cyc = 0; m_word = '0; m_par = '0; first_cyc = 1;
        for (int k = 0; k < 10; k++) m_hist[k] = '0;
    endtask

    // dens: 0 never strobe, d>0 strobe with probability 1/d (external source)
    task automatic step(bit scramble, int dens);
        logic        e_stb;
        logic [9:0]  e_ser;
        logic [39:0] e_par;
        par_i     = {$urandom, $urandom};
        ser_i     = 10'($urandom);
        ext_stb_i = (dens != 0) && ($urandom % dens == 0);
        if (scramble) begin
            dir_i = 1'($urandom); ratio_sel_i = 3'($urandom); tsrc_ext_i = 1'($urandom);
        end
        #1;
        e_stb = m_ext ? ext_stb_i : (m_cyc % m_n == 0);
        e_ser = '0;
        if (!m_dmx && m_pos >= 1 && m_pos <= m_n)
            for (int k = 0; k < m_l; k++) e_ser[k] = m_word[k*m_n + m_n - m_pos];
        e_par = m_dmx ? m_par : '0;
        if (first_cyc) begin
            chk("R9 par", par_o, '0);
            chk("R9 ser", {30'd0, ser_o}, '0);
            first_cyc = 0;
        end
        chk(scramble ? "R1 stb" : (m_ext ? "R4 stb" : "R3 stb"), {39'd0, stb_o}, {39'd0, e_stb});
        chk(scramble ? "R1 ser" : (m_dmx ? "R6 ser" : "R2 R5 R6 ser"), {30'd0, ser_o}, {30'd0, e_ser});
        chk(scramble ? "R1 par" : (m_dmx ? "R7 R8 par" : "R8 par"), par_o, e_par);
        // advance model across the coming edge
        if (m_dmx) begin
            for (int k = 0; k < 10; k++) m_hist[k] = {m_hist[k][38:0], ser_i[k]};
            if (e_stb) begin
                m_par = '0;
                for (int k = 0; k < m_l; k++)
                    for (int i = 0; i < m_n; i++) m_par[k*m_n + i] = m_hist[k][i];
            end
        end else begin
            if (e_stb) begin m_word = par_i; m_pos = 1; end
            else if (m_pos != 0 && m_pos <= m_n) m_pos++;
        end
        m_cyc++;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0424);
        for (int ext = 0; ext < 2; ext++)
            for (int dmx = 0; dmx < 2; dmx++)
                for (int code = 0; code < 8; code++) begin
                    do_reset(dmx, code, ext);
                    repeat (3 * b_ratio(code) + 8) step(0, 4);
                    repeat (2 * b_ratio(code)) step(1, 4);
                end
        // directed: serializer, external source, no strobe then a lone word
        do_reset(0, 7, 1);
        repeat (20) step(0, 0);
        step(0, 1);
        repeat (50) step(0, 0);
        // directed: deserializer code 0, strobe every cycle then long hold
        do_reset(1, 0, 1);
        repeat (12) step(0, 1);
        repeat (30) step(0, 0);
        // directed: back-to-back external words at ratio 4
        do_reset(0, 0, 1);
        repeat (40) step(0, 1);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end
endmodule